// File: doc/BRIEF.md
# Instruction Fetch and Next-PC Unit

This block holds the program counter of a single-cycle processor and supplies the instruction word for the current cycle. The instruction comes from an internal read-only word array. The array is read combinationally from the PC, so a stable PC gives a stable instruction within the same cycle.

On every rising clock edge the block loads a new PC. The new value is either the sequential address, PC + 4, or a PC-relative branch target. The target is PC + 4 plus the sign-extended 16-bit offset with two zero bits appended. Control supplies a branch select that is high only for a compare-and-branch instruction. The datapath supplies an equality flag. The branch is taken only when both are high.

The choice of next PC is modelled as a two-way selection with two named outcomes:
- `NPC_SEQ` is used whenever the branch select or the equality flag is low.
- `NPC_BRANCH` is used when both are high.

A synchronous reset has priority over both outcomes and forces the PC to zero.

Top module: `ifetch_unit`

## Requirements
- R1: A rising edge with `rst` high loads `pc` = 0x00000000.
- R2: A rising edge with `rst` low and `br_sel` low loads `pc` = old `pc` + 4, modulo 2^32.
- R3: A rising edge with `rst`, `br_sel` and `eq_flag` at 0, 1 and 1 loads `pc` = old `pc` + 4 + (`imm16` sign-extended to 32 bits, shifted left by 2), modulo 2^32.
- R4: A rising edge with `br_sel` high and `eq_flag` low loads `pc` = old `pc` + 4, whatever the value of `imm16`.
- R5: A rising edge with `eq_flag` high and `br_sel` low loads `pc` = old `pc` + 4; `imm16` has no effect.
- R6: A negative `imm16` (bit 15 = 1) gives a target below PC + 4. A result that crosses address 0 in either direction wraps at 32 bits; for example, PC 0 with offset 0xFFFE gives 0xFFFFFFFC.
- R7: `instr` equals word k of the array, where k = `pc`[9:2] for the default depth of 256 words. Word k holds (k × 0x9E3779B1) XOR 0x0BADF00D, truncated to 32 bits. Bits of `pc` outside [9:2] do not select the word.
- R8: `rst` has priority: with `rst` high the PC becomes 0 even when both branch inputs are high.
- R9: `pc` bits [1:0] are always 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every update happens on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| br_sel | input | 1 | Branch select from control, high for compare-and-branch |
| eq_flag | input | 1 | Operand equality flag from the datapath |
| imm16 | input | 16 | Signed word offset taken from the current instruction |
| pc | output | 32 | Current program counter |
| instr | output | 32 | Instruction word read combinationally at `pc` |

## Verification
The bench covers four corner cases, each with the failure it would expose:
- **Select and flag each high on its own.** A unit that used OR instead of AND would branch on a set flag with no select, or on a select with no flag.
- **Negative offsets.** A design that zero-extended the offset would jump far forward instead of backward.
- **A backward branch from address 0.** This wraps to the top of the address space and back, and would expose a missing shift or a wrong carry width.
- **Reset asserted together with a taken branch.** A lost reset priority would show up as a non-zero PC.

Every cycle the instruction word is also compared against the array formula, so a wrong index slice shows up as a wrong `instr` on sequential runs.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;
    localparam int unsigned ADDR_W = 32;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned IMM_W  = 16;

    typedef enum logic {
        NPC_SEQ    = 1'b0,
        NPC_BRANCH = 1'b1
    } npc_sel_t;

    localparam logic [WORD_W-1:0] ROM_MIX  = 32'h9E37_79B1;
    localparam logic [WORD_W-1:0] ROM_SEED = 32'h0BAD_F00D;

    function automatic logic [WORD_W-1:0] rom_word(input logic [WORD_W-1:0] idx);
        return (idx * ROM_MIX) ^ ROM_SEED;
    endfunction
endpackage

// File: rtl/ifu_next_pc.sv
module ifu_next_pc
    import ifetch_pkg::*;
(
    input  logic [ADDR_W-1:0] pc_cur,
    input  logic              br_sel,
    input  logic              eq_flag,
    input  logic [IMM_W-1:0]  imm16,
    output logic [ADDR_W-1:0] pc_nxt
);
    localparam int unsigned EXT_W = ADDR_W - IMM_W - 2;

    npc_sel_t          sel;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] offset;

    assign seq_addr = pc_cur + ADDR_W'(4);
    assign offset   = {{EXT_W{imm16[IMM_W-1]}}, imm16, 2'b00};

    always_comb begin
        sel = (br_sel && eq_flag) ? NPC_BRANCH : NPC_SEQ;
    end

    always_comb begin
        unique case (sel)
            NPC_SEQ:    pc_nxt = seq_addr;
            NPC_BRANCH: pc_nxt = seq_addr + offset;
            default:    pc_nxt = seq_addr;
        endcase
    end
endmodule

// File: rtl/ifu_pc_reg.sv
module ifu_pc_reg
    import ifetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] pc_nxt,
    output logic [ADDR_W-1:0] pc_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_nxt;
        end
    end
endmodule

// File: rtl/ifu_imem.sv
module ifu_imem
    import ifetch_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0]  word_idx,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign rom[g] = rom_word(WORD_W'(g));
    end

    assign rdata = rom[word_idx];
endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit
    import ifetch_pkg::*;
#(
    parameter int unsigned IMEM_WORDS = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        br_sel,
    input  logic        eq_flag,
    input  logic [15:0] imm16,
    output logic [31:0] pc,
    output logic [31:0] instr
);
    localparam int unsigned IDX_W = $clog2(IMEM_WORDS);

    logic [ADDR_W-1:0] pc_nxt;

    ifu_next_pc u_next (
        .pc_cur  (pc),
        .br_sel  (br_sel),
        .eq_flag (eq_flag),
        .imm16   (imm16),
        .pc_nxt  (pc_nxt)
    );

    ifu_pc_reg u_pc (
        .clk    (clk),
        .rst    (rst),
        .pc_nxt (pc_nxt),
        .pc_q   (pc)
    );

    ifu_imem #(.DEPTH(IMEM_WORDS)) u_imem (
        .word_idx (pc[IDX_W+1:2]),
        .rdata    (instr)
    );
endmodule

// File: rtl/ifetch_unit_chk.sv
module ifetch_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        br_sel,
    input logic        eq_flag,
    input logic [15:0] imm16,
    input logic [31:0] pc
);
    AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (pc == 32'h0)); // R1
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        !br_sel |=> (pc == $past(pc) + 32'd4)); // R2
    AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (rst)
        (br_sel && eq_flag) |=> (pc == $past(pc) + 32'd4
            + {{14{$past(imm16[15])}}, $past(imm16), 2'b00})); // R3
    AST_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (br_sel && !eq_flag) |=> (pc == $past(pc) + 32'd4)); // R4
    AST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (pc[1:0] == 2'b00)); // R9
endmodule

bind ifetch_unit ifetch_unit_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .br_sel  (br_sel),
    .eq_flag (eq_flag),
    .imm16   (imm16),
    .pc      (pc)
);

// File: tb/ifetch_unit_tb.sv
module ifetch_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        br_sel = 1'b0;
    logic        eq_flag = 1'b0;
    logic [15:0] imm16 = 16'h0;
    logic [31:0] pc;
    logic [31:0] instr;

    int tests = 0;
    int fails = 0;
    logic [31:0] m_pc = 32'h0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ifetch_unit u_dut (
        .clk(clk), .rst(rst), .br_sel(br_sel), .eq_flag(eq_flag),
        .imm16(imm16), .pc(pc), .instr(instr)
    );

    function automatic logic [31:0] exp_instr(input logic [31:0] a);
        logic [31:0] k;
        k = {24'h0, a[9:2]};
        return (k * 32'h9E37_79B1) ^ 32'h0BAD_F00D;
    endfunction

    task automatic check(input string req);
        tests++;
        if (pc !== m_pc) begin
            fails++;
            $display("FAIL %s pc actual=%h expected=%h", req, pc, m_pc);
        end
        tests++;
        if (instr !== exp_instr(m_pc)) begin
            fails++;
            $display("FAIL R7 (%s) instr actual=%h expected=%h", req, instr, exp_instr(m_pc));
        end
    endtask

    // Drive at a falling edge, model the next rising edge, check at the next falling edge.
    task automatic step(input logic r, input logic b, input logic e, input logic [15:0] im,
                        input string req);
        int signed off;
        rst = r; br_sel = b; eq_flag = e; imm16 = im;
        off = int'($signed(im)) * 4;
        if (r) m_pc = 32'h0;
        else if (b && e) m_pc = m_pc + 32'd4 + 32'(off);
        else m_pc = m_pc + 32'd4;
        @(posedge clk);
        @(negedge clk);
        check(req);
    endtask

    initial begin
        #(10 * 5000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(1'b1, 1'b0, 1'b0, 16'h0, "R1");
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0, 16'h1234, "R2");
        step(1'b0, 1'b1, 1'b1, 16'h0010, "R3");
        step(1'b0, 1'b1, 1'b0, 16'h0040, "R4");
        step(1'b0, 1'b0, 1'b1, 16'h0040, "R5");
        step(1'b0, 1'b1, 1'b1, 16'hFFFC, "R6");
        step(1'b0, 1'b1, 1'b1, 16'h0000, "R3");
        step(1'b1, 1'b1, 1'b1, 16'h7FFF, "R8");
        step(1'b0, 1'b1, 1'b1, 16'hFFFE, "R6");
        tests++;
        if (pc !== 32'hFFFF_FFFC) begin
            fails++;
            $display("FAIL R6 wrap actual=%h expected=%h", pc, 32'hFFFF_FFFC);
        end
        step(1'b0, 1'b0, 1'b0, 16'h0, "R2");
        step(1'b0, 1'b1, 1'b1, 16'h7FFF, "R3");
        step(1'b0, 1'b1, 1'b1, 16'h8000, "R6");
        for (int i = 0; i < 300; i++) begin
            logic b, e;
            logic [15:0] im;
            b = 1'($urandom_range(0, 1));
            e = 1'($urandom_range(0, 1));
            im = 16'($urandom);
            step(1'b0, b, e, im, (b && e) ? "R3" : (b ? "R4" : (e ? "R5" : "R2")));
        end
        step(1'b1, 1'b0, 1'b0, 16'h0, "R1");
        for (int i = 0; i < 300; i++) step(1'b0, 1'b0, 1'b0, 16'h0, "R7");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule